// File: doc/BRIEF.md
# Interleaved Four-Word SEC-DED Memory Codec

This block protects a 256-bit memory beat with error-correcting code for a memory built from four device lanes of 72 bits each. On the write side it cuts the beat into four 64-bit words. Each word gets its own extended Hamming code of 8 check bits, which gives a 72-bit codeword. It then cuts every codeword into four 18-bit segments and scatters them. Each lane ends up holding exactly one segment of every codeword. The result is a 288-bit stored word. When one lane fails outright, each codeword loses at most one 18-bit slice.

On the read side the block gathers the segments back into four codewords. It checks and corrects each codeword on its own. It returns the 256-bit data together with a status code and a syndrome for every codeword, plus one summary flag that marks any uncorrectable word as fatal. The encode and decode paths are independent. Each is a valid-qualified pipeline with one registered stage.

Top module: `ilv_ecc_codec`

## Requirements
- R1: Codeword c is built from data bits [64c+63:64c]. Codeword bits 1..71 form a Hamming code. The check bits sit at positions 1, 2, 4, 8, 16, 32 and 64, and each one gives even parity over all positions whose index has that bit set. The 64 data bits fill the remaining positions (3, 5, 6, 7, 9, ...) in ascending order, starting with data bit 0. Codeword bit 0 gives even parity over all 72 bits.
- R2: Stored bits [72L+18k+17 : 72L+18k] of lane L hold segment (k+L) mod 4 of codeword k. Segment s is codeword bits [18s+17 : 18s].
- R3: Each path has a latency of one cycle. enc_valid_o and dec_valid_o are high in exactly the cycle after the matching valid input. While a valid input is low, the data, status and syndrome outputs of that path hold their values.
- R4: A stored word with no error decodes to its original data. Every per-word status is 00 (clean), every per-word syndrome is 0, and dec_fatal_o is 0.
- R5: A single flipped data bit in a codeword is corrected. The word's status is 01 (corrected), and its 8-bit syndrome is {1, position[6:0]} of the flipped codeword bit.
- R6: A single flipped check bit or overall parity bit is corrected without changing the data. The status is 01 and the syndrome is {1, position}, which is 8'h80 for position 0.
- R7: Two flipped bits in one codeword give status 10 (uncorrectable). The syndrome is {0, XOR of the two positions}, the word's data is passed on uncorrected, and dec_fatal_o is 1.
- R8: Status, syndrome and data of a codeword depend only on that codeword's own bits. An error in one word leaves the other words clean and exact.
- R9: One flipped bit in every codeword at the same time, as when a single lane corrupts one bit of each segment it holds, is corrected in all four words, with every status 01 and dec_fatal_o 0.
- R10: dec_fatal_o is high exactly when at least one word's status is 10. After reset, both valid outputs, dec_fatal_o, every status and every syndrome are 0.
- R11: An odd-parity pattern whose 7-bit syndrome points past position 71 is reported as uncorrectable (status 10), and the word is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid_i | input | 1 | Write beat valid |
| enc_data_i | input | 256 | Write data beat |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_word_o | output | 288 | Interleaved stored word, four 72-bit lanes |
| dec_valid_i | input | 1 | Read word valid |
| dec_word_i | input | 288 | Interleaved stored word read back |
| dec_valid_o | output | 1 | Decoded beat valid |
| dec_data_o | output | 256 | Corrected data beat |
| dec_status_o | output | 8 | Two bits per word: 00 clean, 01 corrected, 10 uncorrectable |
| dec_syndrome_o | output | 32 | Eight bits per word: {overall parity mismatch, 7-bit Hamming syndrome} |
| dec_fatal_o | output | 1 | At least one word is uncorrectable |

## Verification
The hardest case to reach is a syndrome that carries odd parity yet points past the last codeword position. No single or double error can produce it. The bench gets there with a deliberate triple flip of positions 1, 8 and 64 in one codeword, whose XOR is 73. Placing any error at all requires knowing where a given codeword bit lands among the 288 stored bits. The bench therefore computes the lane, slot and offset of every flip from the stated rotation. It uses the same mapping to aim one flip into each codeword through a single lane, which imitates a device that corrupts one bit in every segment it holds.

// File: rtl/ilv_ecc_pkg.sv
package ilv_ecc_pkg;

   localparam int MAX_CW = 256;

   typedef enum logic [1:0] {
      ST_CLEAN = 2'b00,
      ST_FIXED = 2'b01,
      ST_FATAL = 2'b10
   } ecc_st_e;

   // smallest r with 2^r >= dw + r + 1
   function automatic int ham_bits(int dw);
      int r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   function automatic bit is_pow2(int p);
      return (p != 0) && ((p & (p - 1)) == 0);
   endfunction

   // codeword position of data bit d
   function automatic int data_pos(int d);
      int cnt = 0;
      int hit = 0;
      for (int p = 1; p < MAX_CW; p++) begin
         if (!is_pow2(p)) begin
            if (cnt == d && hit == 0) hit = p;
            cnt++;
         end
      end
      return hit;
   endfunction

   // positions whose index has bit r set
   function automatic logic [MAX_CW-1:0] sel_mask(int r);
      logic [MAX_CW-1:0] m;
      for (int p = 0; p < MAX_CW; p++) m[p] = ((p >> r) & 1) == 1;
      return m;
   endfunction

endpackage

// File: rtl/secded_word_enc.sv
module secded_word_enc
   import ilv_ecc_pkg::*;
#(
   parameter int WORD_W = 64,
   localparam int HAM_W = ham_bits(WORD_W),
   localparam int CW_W  = WORD_W + HAM_W + 1
) (
   input  logic [WORD_W-1:0] data_i,
   output logic [CW_W-1:0]   cw_o
);

   logic [CW_W-1:0] placed;

   assign placed[0] = 1'b0;

   for (genvar r = 0; r < HAM_W; r++) begin : g_zero
      assign placed[1 << r] = 1'b0;
   end

   for (genvar d = 0; d < WORD_W; d++) begin : g_place
      localparam int P = data_pos(d);
      assign placed[P] = data_i[d];
   end

   always_comb begin
      logic [MAX_CW-1:0] m;
      cw_o = placed;
      for (int r = 0; r < HAM_W; r++) begin
         m = sel_mask(r);
         cw_o[1 << r] = ^(placed & m[CW_W-1:0]);
      end
      cw_o[0] = ^cw_o[CW_W-1:1];
   end

endmodule

// File: rtl/secded_word_dec.sv
module secded_word_dec
   import ilv_ecc_pkg::*;
#(
   parameter int WORD_W = 64,
   localparam int HAM_W = ham_bits(WORD_W),
   localparam int CW_W  = WORD_W + HAM_W + 1,
   localparam int SYN_W = HAM_W + 1
) (
   input  logic [CW_W-1:0]   cw_i,
   output logic [WORD_W-1:0] data_o,
   output logic [1:0]        status_o,
   output logic [SYN_W-1:0]  syndrome_o
);

   logic [HAM_W-1:0] syn;
   logic             par;
   logic [CW_W-1:0]  flip;
   logic [CW_W-1:0]  fixed;

   always_comb begin
      logic [MAX_CW-1:0] m;
      for (int r = 0; r < HAM_W; r++) begin
         m = sel_mask(r);
         syn[r] = ^(cw_i & m[CW_W-1:0]);
      end
      par = ^cw_i;
   end

   always_comb begin
      flip = '0;
      if (!par && syn == '0) begin
         status_o = ST_CLEAN;
      end else if (par && int'(syn) < CW_W) begin
         status_o = ST_FIXED;
         flip[syn] = 1'b1;
      end else begin
         status_o = ST_FATAL;
      end
   end

   assign fixed      = cw_i ^ flip;
   assign syndrome_o = {par, syn};

   for (genvar d = 0; d < WORD_W; d++) begin : g_pick
      localparam int P = data_pos(d);
      assign data_o[d] = fixed[P];
   end

endmodule

// File: rtl/lane_map.sv
module lane_map #(
   parameter int N      = 4,
   parameter int SEG_W  = 18,
   parameter bit GATHER = 1'b0,
   localparam int TOT_W = N * N * SEG_W
) (
   input  logic [TOT_W-1:0] word_i,
   output logic [TOT_W-1:0] word_o
);

   // lane L, slot k <-> codeword k, segment (k+L) mod N
   for (genvar L = 0; L < N; L++) begin : g_lane
      for (genvar k = 0; k < N; k++) begin : g_slot
         localparam int S   = (k + L) % N;
         localparam int STO = (L * N + k) * SEG_W;
         localparam int CWB = (k * N + S) * SEG_W;
         if (GATHER) begin : g_gather
            assign word_o[CWB +: SEG_W] = word_i[STO +: SEG_W];
         end else begin : g_scatter
            assign word_o[STO +: SEG_W] = word_i[CWB +: SEG_W];
         end
      end
   end

endmodule

// File: rtl/ilv_ecc_codec.sv
module ilv_ecc_codec
   import ilv_ecc_pkg::*;
#(
   parameter int DATA_W  = 256,
   parameter int N_WORDS = 4,
   parameter int N_LANES = 4,
   localparam int WORD_W  = DATA_W / N_WORDS,
   localparam int HAM_W   = ham_bits(WORD_W),
   localparam int CW_W    = WORD_W + HAM_W + 1,
   localparam int SEG_W   = CW_W / N_LANES,
   localparam int STORE_W = CW_W * N_WORDS,
   localparam int SYN_W   = HAM_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       enc_valid_i,
   input  logic [DATA_W-1:0]          enc_data_i,
   output logic                       enc_valid_o,
   output logic [STORE_W-1:0]         enc_word_o,
   input  logic                       dec_valid_i,
   input  logic [STORE_W-1:0]         dec_word_i,
   output logic                       dec_valid_o,
   output logic [DATA_W-1:0]          dec_data_o,
   output logic [2*N_WORDS-1:0]       dec_status_o,
   output logic [SYN_W*N_WORDS-1:0]   dec_syndrome_o,
   output logic                       dec_fatal_o
);

   if (N_LANES != N_WORDS) begin : g_bad_lanes
      $error("lane count must equal codeword count");
   end
   if (DATA_W % N_WORDS != 0) begin : g_bad_split
      $error("data width must split evenly into words");
   end
   if (CW_W % N_LANES != 0) begin : g_bad_seg
      $error("codeword must split evenly into lane segments");
   end
   if (CW_W > MAX_CW) begin : g_bad_cw
      $error("codeword wider than supported");
   end

   logic [STORE_W-1:0]       enc_cws;
   logic [STORE_W-1:0]       enc_store;
   logic [STORE_W-1:0]       dec_cws;
   logic [DATA_W-1:0]        dec_data_c;
   logic [2*N_WORDS-1:0]     dec_st_c;
   logic [SYN_W*N_WORDS-1:0] dec_syn_c;
   logic                     dec_fatal_c;

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      secded_word_enc #(.WORD_W(WORD_W)) u_enc (
         .data_i (enc_data_i[w*WORD_W +: WORD_W]),
         .cw_o   (enc_cws[w*CW_W +: CW_W])
      );
      secded_word_dec #(.WORD_W(WORD_W)) u_dec (
         .cw_i       (dec_cws[w*CW_W +: CW_W]),
         .data_o     (dec_data_c[w*WORD_W +: WORD_W]),
         .status_o   (dec_st_c[2*w +: 2]),
         .syndrome_o (dec_syn_c[w*SYN_W +: SYN_W])
      );
   end

   lane_map #(.N(N_LANES), .SEG_W(SEG_W), .GATHER(1'b0)) u_scatter (
      .word_i (enc_cws),
      .word_o (enc_store)
   );

   lane_map #(.N(N_LANES), .SEG_W(SEG_W), .GATHER(1'b1)) u_gather (
      .word_i (dec_word_i),
      .word_o (dec_cws)
   );

   always_comb begin
      dec_fatal_c = 1'b0;
      for (int w = 0; w < N_WORDS; w++)
         if (dec_st_c[2*w +: 2] == ST_FATAL) dec_fatal_c = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enc_valid_o <= 1'b0;
         enc_word_o  <= '0;
      end else begin
         enc_valid_o <= enc_valid_i;
         if (enc_valid_i) enc_word_o <= enc_store;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid_o    <= 1'b0;
         dec_data_o     <= '0;
         dec_status_o   <= '0;
         dec_syndrome_o <= '0;
         dec_fatal_o    <= 1'b0;
      end else begin
         dec_valid_o <= dec_valid_i;
         if (dec_valid_i) begin
            dec_data_o     <= dec_data_c;
            dec_status_o   <= dec_st_c;
            dec_syndrome_o <= dec_syn_c;
            dec_fatal_o    <= dec_fatal_c;
         end
      end
   end

   function automatic logic any_fatal(logic [2*N_WORDS-1:0] st);
      logic f = 1'b0;
      for (int w = 0; w < N_WORDS; w++)
         if (st[2*w +: 2] == ST_FATAL) f = 1'b1;
      return f;
   endfunction

   // R3
   enc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid_i |=> enc_valid_o);

   // R3
   dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid_i |=> $stable(dec_data_o) && $stable(dec_status_o) && !dec_valid_o);

   // R10
   fatal_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_fatal_o == any_fatal(dec_status_o));

   for (genvar w = 0; w < N_WORDS; w++) begin : g_chk
      // R4
      clean_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_status_o[2*w +: 2] == ST_CLEAN) |-> (dec_syndrome_o[w*SYN_W +: SYN_W] == '0));
      // R5
      fixed_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_status_o[2*w +: 2] == ST_FIXED) |-> dec_syndrome_o[w*SYN_W + SYN_W - 1]);
      // R10
      status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dec_status_o[2*w +: 2] != 2'b11);
   end

endmodule

// File: tb/sim_ilv_ecc_codec.sv
module sim_ilv_ecc_codec;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enc_valid_i = 1'b0;
   logic [255:0] enc_data_i = '0;
   logic         enc_valid_o;
   logic [287:0] enc_word_o;
   logic         dec_valid_i = 1'b0;
   logic [287:0] dec_word_i = '0;
   logic         dec_valid_o;
   logic [255:0] dec_data_o;
   logic [7:0]   dec_status_o;
   logic [31:0]  dec_syndrome_o;
   logic         dec_fatal_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   ilv_ecc_codec u0 (
      .clk(clk), .rst_n(rst_n),
      .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
      .enc_valid_o(enc_valid_o), .enc_word_o(enc_word_o),
      .dec_valid_i(dec_valid_i), .dec_word_i(dec_word_i),
      .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
      .dec_status_o(dec_status_o), .dec_syndrome_o(dec_syndrome_o),
      .dec_fatal_o(dec_fatal_o)
   );

   task automatic chk(input bit ok, input string req, input logic [287:0] act, input logic [287:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit [71:0] ref_cw(bit [63:0] d);
      bit [71:0] cw = '0;
      int di = 0;
      for (int p = 1; p < 72; p++)
         if ((p & (p - 1)) != 0) begin cw[p] = d[di]; di++; end
      for (int r = 0; r < 7; r++) begin
         bit x = 1'b0;
         for (int p = 1; p < 72; p++) if (p[r]) x ^= cw[p];
         cw[1 << r] = x;
      end
      cw[0] = ^cw[71:1];
      return cw;
   endfunction

   function automatic int sidx(int c, int p);
      int s = p / 18;
      int l = (s - c + 4) % 4;
      return 72 * l + 18 * c + (p % 18);
   endfunction

   function automatic bit [287:0] ref_store(bit [255:0] d);
      bit [287:0] st = '0;
      for (int c = 0; c < 4; c++) begin
         bit [71:0] cw = ref_cw(d[64*c +: 64]);
         for (int p = 0; p < 72; p++) st[sidx(c, p)] = cw[p];
      end
      return st;
   endfunction

   function automatic bit [255:0] pat(int i);
      bit [255:0] d;
      for (int k = 0; k < 8; k++) d[32*k +: 32] = 32'h9E37_79B9 * (k + 3 + 11 * i) ^ (32'h5A5A_0F0F << i);
      return d;
   endfunction

   task automatic do_enc(input logic [255:0] d);
      @(negedge clk);
      enc_data_i = d; enc_valid_i = 1'b1;
      @(negedge clk);
      enc_valid_i = 1'b0;
   endtask

   task automatic do_dec(input logic [287:0] w);
      @(negedge clk);
      dec_word_i = w; dec_valid_i = 1'b1;
      @(negedge clk);
      dec_valid_i = 1'b0;
   endtask

   task automatic t_reset();
      chk(enc_valid_o == 1'b0, "R10 enc_valid reset", enc_valid_o, 0);
      chk(dec_valid_o == 1'b0, "R10 dec_valid reset", dec_valid_o, 0);
      chk(dec_fatal_o == 1'b0, "R10 fatal reset", dec_fatal_o, 0);
      chk(dec_status_o == 8'h00 && dec_syndrome_o == 32'h0, "R10 status reset",
          {dec_status_o, dec_syndrome_o}, 0);
   endtask

   task automatic t_encode();
      do_enc('0);
      chk(enc_valid_o == 1'b1, "R3 enc_valid one cycle", enc_valid_o, 1);
      chk(enc_word_o == '0, "R1 zero beat", enc_word_o, 0);
      @(negedge clk);
      chk(enc_valid_o == 1'b0, "R3 enc_valid drops", enc_valid_o, 0);
      do_enc(256'h1);
      chk(enc_word_o == 288'hF, "R1 R2 data bit 0 layout", enc_word_o, 288'hF);
      for (int i = 0; i < 4; i++) begin
         logic [255:0] d = pat(i);
         do_enc(d);
         chk(enc_word_o == ref_store(d), "R1 R2 pattern", enc_word_o, ref_store(d));
      end
   endtask

   task automatic t_clean();
      for (int i = 0; i < 3; i++) begin
         logic [255:0] d = pat(i + 5);
         do_dec(ref_store(d));
         chk(dec_valid_o == 1'b1, "R3 dec_valid", dec_valid_o, 1);
         chk(dec_data_o == d, "R4 clean data", dec_data_o, d);
         chk(dec_status_o == 8'h00 && dec_syndrome_o == 32'h0 && !dec_fatal_o, "R4 clean status",
             {dec_fatal_o, dec_status_o, dec_syndrome_o}, 0);
      end
   endtask

   task automatic t_single_data();
      logic [255:0] d = pat(9);
      logic [287:0] w = ref_store(d);
      w[sidx(2, 37)] ^= 1'b1;
      do_dec(w);
      chk(dec_data_o == d, "R5 corrected data", dec_data_o, d);
      chk(dec_status_o == 8'h10, "R5 R8 status", dec_status_o, 8'h10);
      chk(dec_syndrome_o == {8'h00, 8'hA5, 16'h0}, "R5 syndrome", dec_syndrome_o, {8'h00, 8'hA5, 16'h0});
      chk(dec_fatal_o == 1'b0, "R5 not fatal", dec_fatal_o, 0);
   endtask

   task automatic t_single_check();
      logic [255:0] d = pat(12);
      logic [287:0] w = ref_store(d);
      w[sidx(1, 16)] ^= 1'b1;
      do_dec(w);
      chk(dec_data_o == d, "R6 check bit data unchanged", dec_data_o, d);
      chk(dec_status_o == 8'h04, "R6 check bit status", dec_status_o, 8'h04);
      chk(dec_syndrome_o[15:8] == 8'h90, "R6 check bit syndrome", dec_syndrome_o[15:8], 8'h90);
      w = ref_store(d);
      w[sidx(3, 0)] ^= 1'b1;
      do_dec(w);
      chk(dec_data_o == d, "R6 parity bit data unchanged", dec_data_o, d);
      chk(dec_status_o == 8'h40 && dec_syndrome_o[31:24] == 8'h80, "R6 parity bit status",
          {dec_status_o, dec_syndrome_o}, {8'h40, 32'h8000_0000});
   endtask

   task automatic t_double();
      logic [255:0] d = pat(14);
      logic [287:0] w = ref_store(d);
      logic [255:0] exp = d;
      exp[63:0] ^= 64'h12;
      w[sidx(0, 5)] ^= 1'b1;
      w[sidx(0, 9)] ^= 1'b1;
      do_dec(w);
      chk(dec_status_o == 8'h02, "R7 R8 status", dec_status_o, 8'h02);
      chk(dec_fatal_o == 1'b1, "R7 R10 fatal", dec_fatal_o, 1);
      chk(dec_syndrome_o == 32'h0000_000C, "R7 syndrome", dec_syndrome_o, 32'hC);
      chk(dec_data_o == exp, "R7 R8 data", dec_data_o, exp);
   endtask

   task automatic t_every_word();
      logic [255:0] d = pat(17);
      logic [287:0] w = ref_store(d);
      for (int k = 0; k < 4; k++) w[72 + 18 * k + 3] ^= 1'b1;
      do_dec(w);
      chk(dec_status_o == 8'h55, "R9 all corrected", dec_status_o, 8'h55);
      chk(dec_fatal_o == 1'b0, "R9 not fatal", dec_fatal_o, 0);
      chk(dec_data_o == d, "R9 data", dec_data_o, d);
   endtask

   task automatic t_out_of_range();
      logic [255:0] d = pat(20);
      logic [287:0] w = ref_store(d);
      logic [255:0] exp = d;
      w[sidx(0, 1)] ^= 1'b1;
      w[sidx(0, 8)] ^= 1'b1;
      w[sidx(0, 64)] ^= 1'b1;
      do_dec(w);
      chk(dec_status_o == 8'h02 && dec_fatal_o, "R11 status", {dec_fatal_o, dec_status_o}, 9'h102);
      chk(dec_syndrome_o[7:0] == 8'hC9, "R11 syndrome", dec_syndrome_o[7:0], 8'hC9);
      chk(dec_data_o == exp, "R11 data untouched", dec_data_o, exp);
   endtask

   task automatic t_hold();
      logic [255:0] d = pat(23);
      do_dec(ref_store(d));
      @(negedge clk);
      dec_word_i = ~ref_store(d);
      @(negedge clk);
      chk(dec_valid_o == 1'b0, "R3 no valid", dec_valid_o, 0);
      chk(dec_data_o == d && dec_status_o == 8'h00, "R3 hold", dec_data_o, d);
   endtask

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_encode();
      t_clean();
      t_single_data();
      t_single_check();
      t_double();
      t_every_word();
      t_out_of_range();
      t_hold();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule